// File: doc/BRIEF.md
# Transfer Completion Interrupt Controller

This block raises the two completion interrupts of a byte-oriented point-to-point transmit port. One event, "external done", marks the moment the last byte has actually left the port. The other, "internal done", marks the moment the transfer's word count has run out. Each event sets a sticky bit in a two-bit status word. The core collects the status word with a read that clears the bits it returns. A combined interrupt line reports any status bit whose enable bit is set in the port's control word.

The completion rules depend on the transfer mode:

- **Without DMA**, the external event comes from an empty transmit FIFO together with the last-byte-sent strobe. The internal event comes from a zero word count.
- **With DMA**, both events wait for the DMA count to reach zero. If descriptor chaining is also on, both events also wait for the chain pointer to reach zero.

A status read can meet a new event in the same cycle. In that case the block stalls the core for one cycle, so the new bit lands before the read is taken and the clear-on-read cannot drop it. The serializer, the FIFO, DMA address generation and descriptor fetch are outside the block. They appear only as input signals.

Top module: `xfer_cmpl_irq`

## Requirements
- R1: `irq` is high exactly when a status bit is set and its enable bit in `ctrl_word` is also set. Bit 10 of `ctrl_word` enables internal done (status bit 0). Bit 12 enables external done (status bit 1).
- R2: With `dma_en` low, `txfifo_empty` high together with a `last_byte_sent` pulse sets status bit 1 on the next clock edge. The same pulse with the FIFO not empty sets nothing.
- R3: With `dma_en` low, `word_count` becoming zero sets status bit 0 on the next clock edge.
- R4: With `dma_en` high, both events wait for `dma_count` to be zero, and the FIFO, strobe and word-count inputs have no effect. When `dma_count` becomes zero, both status bits set on the next edge.
- R5: With `dma_en` and `chain_en` both high, a zero `dma_count` sets nothing while `chain_ptr` is nonzero. Both bits set one edge after `chain_ptr` also becomes zero.
- R6: A read (`stat_rd` high, `rd_stall` low) asserts `rd_ack` in that cycle and places the status word on `rd_data`. The bits it returns are clear after the clock edge.
- R7: A read that meets an event in the same cycle gets `rd_stall` for exactly one cycle. The core holds `stat_rd`, and the read taken in the following cycle returns the new bit.
- R8: No value of `ctrl_word` prevents or shortens the read stall of R7.
- R9: Events trigger on the rising edge of their condition. A condition that stays true does not set its bit again after a read has cleared it.
- R10: An event whose enable bit is clear still sets its status bit, and leaves `irq` low.
- R11: Synchronous active-high `rst` clears both status bits and holds `irq` and `rd_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Port control word; bit 12 enables external done, bit 10 enables internal done |
| dma_en | input | 1 | DMA mode selected |
| chain_en | input | 1 | Descriptor chaining selected |
| txfifo_empty | input | 1 | Transmit FIFO holds no data |
| last_byte_sent | input | 1 | Pulse: the last byte has been shifted out |
| word_count | input | 16 | Remaining word count |
| dma_count | input | 16 | Current DMA count |
| chain_ptr | input | 19 | Next descriptor pointer |
| stat_rd | input | 1 | Core read request for the status word, held while stalled |
| rd_stall | output | 1 | Read held off for one cycle |
| rd_ack | output | 1 | Read taken this cycle |
| rd_data | output | 2 | Status word returned by the read (bit 0 internal, bit 1 external) |
| stat_bits | output | 2 | Current status bits |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest situation to reach is a status read that arrives in exactly the cycle a completion condition rises. That is the only cycle in which the stall appears. The stimulus sets up this collision directly: in a single input update it drives the word count to zero and raises the read request. It then repeats the collision with the control word set to all zeros and to all ones, and it checks that the held read returns the new bit in the cycle after the stall.

// File: rtl/xci_pkg.sv
package xci_pkg;

    localparam int CTRL_W_DEF  = 16;
    localparam int CNT_W_DEF   = 16;
    localparam int PTR_W_DEF   = 19;
    localparam int EN_EXT_POS  = 12;
    localparam int EN_INT_POS  = 10;
    localparam int SRC_N       = 2;

    typedef enum int {
        SRC_INT = 0,
        SRC_EXT = 1
    } src_idx_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic dma_en;
        logic chain_en;
        logic fifo_empty;
        logic last_byte;
        logic wc_zero;
        logic dc_zero;
        logic cp_zero;
    } port_state_t;

    function automatic logic dma_finished(input port_state_t s);
        return s.dc_zero && (!s.chain_en || s.cp_zero);
    endfunction

    function automatic src_vec_t eval_conditions(input port_state_t s);
        src_vec_t c;
        if (s.dma_en) begin
            c[SRC_INT] = dma_finished(s);
            c[SRC_EXT] = dma_finished(s);
        end else begin
            c[SRC_INT] = s.wc_zero;
            c[SRC_EXT] = s.fifo_empty && s.last_byte;
        end
        return c;
    endfunction

endpackage

// File: rtl/xci_cond_eval.sv
module xci_cond_eval
    import xci_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic             dma_en,
    input  logic             chain_en,
    input  logic             txfifo_empty,
    input  logic             last_byte_sent,
    input  logic [CNT_W-1:0] word_count,
    input  logic [CNT_W-1:0] dma_count,
    input  logic [PTR_W-1:0] chain_ptr,
    output src_vec_t         cond_vec
);

    port_state_t st;

    always_comb begin
        st.dma_en     = dma_en;
        st.chain_en   = chain_en;
        st.fifo_empty = txfifo_empty;
        st.last_byte  = last_byte_sent;
        st.wc_zero    = (word_count == '0);
        st.dc_zero    = (dma_count == '0);
        st.cp_zero    = (chain_ptr == '0);
        cond_vec      = eval_conditions(st);
    end

endmodule

// File: rtl/xci_edge_detect.sv
module xci_edge_detect
    import xci_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t cond_vec,
    output src_vec_t evt_vec
);

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= cond_vec[g];
        end

        assign evt_vec[g] = cond_vec[g] & ~prev_q;
    end

endmodule

// File: rtl/xci_status_ctl.sv
module xci_status_ctl
    import xci_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_vec,
    input  logic     rd_req,
    output logic     rd_stall,
    output logic     rd_ack,
    output src_vec_t rd_data,
    output src_vec_t stat_q
);

    logic     stalled_q;
    src_vec_t clr_vec;
    src_vec_t stat_d;

    always_comb begin
        rd_stall = rd_req & (|evt_vec) & ~stalled_q;
        rd_ack   = rd_req & ~rd_stall;
        clr_vec  = rd_ack ? stat_q : '0;
        rd_data  = rd_ack ? stat_q : '0;
        stat_d   = (stat_q & ~clr_vec) | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            stalled_q <= 1'b0;
        end else begin
            stat_q    <= stat_d;
            stalled_q <= rd_stall;
        end
    end

endmodule

// File: rtl/xci_irq_merge.sv
module xci_irq_merge
    import xci_pkg::*;
#(
    parameter int CTRL_W = CTRL_W_DEF,
    parameter int EXT_POS = EN_EXT_POS,
    parameter int INT_POS = EN_INT_POS
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  src_vec_t          stat_q,
    output logic              irq
);

    src_vec_t en_vec;

    assign en_vec[SRC_INT] = ctrl_word[INT_POS];
    assign en_vec[SRC_EXT] = ctrl_word[EXT_POS];

    assign irq = |(stat_q & en_vec);

endmodule

// File: rtl/xfer_cmpl_irq.sv
module xfer_cmpl_irq
    import xci_pkg::*;
#(
    parameter int CTRL_W = CTRL_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PTR_W  = PTR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              dma_en,
    input  logic              chain_en,
    input  logic              txfifo_empty,
    input  logic              last_byte_sent,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [CNT_W-1:0]  dma_count,
    input  logic [PTR_W-1:0]  chain_ptr,
    input  logic              stat_rd,
    output logic              rd_stall,
    output logic              rd_ack,
    output logic [1:0]        rd_data,
    output logic [1:0]        stat_bits,
    output logic              irq
);

    src_vec_t cond_vec;
    src_vec_t evt_vec;
    src_vec_t stat_q;
    src_vec_t rd_vec;

    xci_cond_eval #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_cond (
        .dma_en         (dma_en),
        .chain_en       (chain_en),
        .txfifo_empty   (txfifo_empty),
        .last_byte_sent (last_byte_sent),
        .word_count     (word_count),
        .dma_count      (dma_count),
        .chain_ptr      (chain_ptr),
        .cond_vec       (cond_vec)
    );

    xci_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .cond_vec (cond_vec),
        .evt_vec  (evt_vec)
    );

    xci_status_ctl u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt_vec  (evt_vec),
        .rd_req   (stat_rd),
        .rd_stall (rd_stall),
        .rd_ack   (rd_ack),
        .rd_data  (rd_vec),
        .stat_q   (stat_q)
    );

    xci_irq_merge #(.CTRL_W(CTRL_W)) u_irq (
        .ctrl_word (ctrl_word),
        .stat_q    (stat_q),
        .irq       (irq)
    );

    assign rd_data   = rd_vec;
    assign stat_bits = stat_q;

endmodule

// File: rtl/xci_checker.sv
module xci_checker (
    input logic       clk,
    input logic       rst,
    input logic       stat_rd,
    input logic       rd_stall,
    input logic       rd_ack,
    input logic [1:0] rd_data,
    input logic [1:0] stat_bits,
    input logic [1:0] evt_vec,
    input logic       irq
);

    AST_NO_IRQ_WITHOUT_STATUS: assert property (@(posedge clk) disable iff (rst)
        (stat_bits == 2'b00) |-> !irq); // R1

    AST_ACK_CLEARS_RETURNED: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> ((stat_bits & $past(rd_data) & ~$past(evt_vec)) == 2'b00)); // R6

    AST_ACK_EXCLUDES_STALL: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> !rd_stall); // R6

    AST_STALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_stall |=> !rd_stall); // R7

    AST_STALL_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        rd_stall |-> stat_rd); // R7

    AST_STALL_BIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        rd_stall |=> (stat_bits != 2'b00)); // R7

    AST_STICKY_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_ack |=> ((stat_bits & $past(stat_bits)) == $past(stat_bits))); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (stat_bits == 2'b00 && !irq)); // R11

endmodule

bind xfer_cmpl_irq xci_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .stat_rd   (stat_rd),
    .rd_stall  (rd_stall),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .stat_bits (stat_bits),
    .evt_vec   (evt_vec),
    .irq       (irq)
);

// File: tb/xfer_cmpl_irq_tb_top.sv
module xfer_cmpl_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_word = '0;
    logic        dma_en = 1'b0;
    logic        chain_en = 1'b0;
    logic        txfifo_empty = 1'b0;
    logic        last_byte_sent = 1'b0;
    logic [15:0] word_count = 16'd9;
    logic [15:0] dma_count = 16'd9;
    logic [18:0] chain_ptr = 19'd5;
    logic        stat_rd = 1'b0;
    logic        rd_stall;
    logic        rd_ack;
    logic [1:0]  rd_data;
    logic [1:0]  stat_bits;
    logic        irq;

    int total = 0;
    int fails = 0;
    logic [1:0] exp_q [$];

    always #2 clk = ~clk;

    xfer_cmpl_irq dut_i (
        .clk            (clk),
        .rst            (rst),
        .ctrl_word      (ctrl_word),
        .dma_en         (dma_en),
        .chain_en       (chain_en),
        .txfifo_empty   (txfifo_empty),
        .last_byte_sent (last_byte_sent),
        .word_count     (word_count),
        .dma_count      (dma_count),
        .chain_ptr      (chain_ptr),
        .stat_rd        (stat_rd),
        .rd_stall       (rd_stall),
        .rd_ack         (rd_ack),
        .rd_data        (rd_data),
        .stat_bits      (stat_bits),
        .irq            (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    // Driver: queue expected read data, hold request through any stall.
    task automatic do_read(input logic [1:0] exp, output int stalls);
        stat_rd = 1'b1;
        exp_q.push_back(exp);
        stalls = 0;
        @(negedge clk);
        while (rd_stall) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk); #1;
        stat_rd = 1'b0;
    endtask

    // Monitor: compare each taken read against the scoreboard.
    always @(negedge clk) begin
        if (!rst && rd_ack) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected ack", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check("R6/R7 read data", int'(rd_data), int'(e));
            end
        end
    end

    task automatic collide(input logic [15:0] cw, input string tag);
        int st;
        ctrl_word = cw;
        word_count = 16'd9;
        step();
        step();
        word_count = 16'd0;
        do_read(2'b01, st);
        check(tag, st, 1);
        @(negedge clk);
        check({tag, " bit cleared"}, int'(stat_bits), 0);
        step();
        word_count = 16'd9;
        step();
    endtask

    initial begin
        #800000;
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int st;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 status after reset", int'(stat_bits), 0);
        check("R11 irq after reset", int'(irq), 0);
        check("R11 ack after reset", int'(rd_ack), 0);

        // R3 word count zero, masked (R10)
        step();
        word_count = 16'd0;
        settle();
        check("R3 internal bit set", int'(stat_bits), 1);
        check("R10 masked irq low", int'(irq), 0);
        ctrl_word = 16'h0400;
        #1;
        check("R1 irq with bit 10", int'(irq), 1);
        ctrl_word = 16'h1000;
        #1;
        check("R1 irq with only bit 12", int'(irq), 0);

        // R6 read clears
        step();
        do_read(2'b01, st);
        check("R6 no stall on quiet read", st, 0);
        @(negedge clk);
        check("R6 cleared after read", int'(stat_bits), 0);

        // R9 held condition does not re-set
        repeat (4) step();
        @(negedge clk);
        check("R9 no re-set while held", int'(stat_bits), 0);
        step();
        word_count = 16'd3;
        step();
        word_count = 16'd0;
        settle();
        check("R9 re-set on new edge", int'(stat_bits), 1);
        step();
        do_read(2'b01, st);
        word_count = 16'd9;

        // R2 external done
        txfifo_empty = 1'b0;
        last_byte_sent = 1'b1;
        step();
        last_byte_sent = 1'b0;
        @(negedge clk);
        check("R2 fifo not empty ignored", int'(stat_bits), 0);
        step();
        txfifo_empty = 1'b1;
        last_byte_sent = 1'b1;
        step();
        last_byte_sent = 1'b0;
        @(negedge clk);
        check("R2 external bit set", int'(stat_bits), 2);
        check("R1 irq with bit 12", int'(irq), 1);
        ctrl_word = 16'h0400;
        #1;
        check("R1 ext masked by bit 10 only", int'(irq), 0);
        step();
        do_read(2'b10, st);

        // R4 DMA mode
        dma_count = 16'd7;
        dma_en = 1'b1;
        word_count = 16'd0;
        last_byte_sent = 1'b1;
        step();
        last_byte_sent = 1'b0;
        @(negedge clk);
        check("R4 non-DMA inputs ignored", int'(stat_bits), 0);
        step();
        dma_count = 16'd0;
        settle();
        check("R4 both bits on dma zero", int'(stat_bits), 3);
        step();
        do_read(2'b11, st);

        // R5 chaining
        chain_en = 1'b1;
        chain_ptr = 19'd3;
        dma_count = 16'd4;
        step();
        dma_count = 16'd0;
        settle();
        check("R5 pointer nonzero blocks", int'(stat_bits), 0);
        step();
        chain_ptr = 19'd0;
        settle();
        check("R5 both bits on pointer zero", int'(stat_bits), 3);
        step();
        do_read(2'b11, st);

        // back to non-DMA, idle
        dma_en = 1'b0;
        chain_en = 1'b0;
        word_count = 16'd9;
        txfifo_empty = 1'b0;
        step();

        // R7 / R8 collisions
        collide(16'h1400, "R7 stall on collision");
        collide(16'h0000, "R8 stall with ctrl zero");
        collide(16'hFFFF, "R8 stall with ctrl ones");

        // quiet read of empty status
        do_read(2'b00, st);
        check("R6 empty read no stall", st, 0);

        // R11 mid-run reset
        word_count = 16'd0;
        settle();
        check("R11 bit before reset", int'(stat_bits), 1);
        step();
        word_count = 16'd9;
        rst = 1'b1;
        step();
        rst = 1'b0;
        @(negedge clk);
        check("R11 cleared by reset", int'(stat_bits), 0);
        check("R11 irq low after reset", int'(irq), 0);

        step();
        check("R6 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule